// File: doc/BRIEF.md
# Receive Sync and Frame Deframer

This block sits behind a clock-recovery stage and accepts one recovered bit each time a bit-enable strobe is high. Once the host pulls the active-low receive-commence control low, the block hunts for a configurable sync word. After one match it looks for a configurable frame delimiter, which may follow any number of repeated sync words. After the delimiter it strips the bits that the transmitter inserted to force transitions. It packs the remaining bits into bytes for a FIFO write port and runs a CRC-32 over them.

The host supplies a 16-bit payload length as two bytes and a valid qualifier. The length may arrive while the frame is already streaming. When the payload and the four trailing CRC bytes have all been written, the CRC verdict is posted. If no sync word turns up within a programmable number of bit times, a sync-done flag and a one-cycle interrupt are raised. The host then reads a busy or clear channel verdict from the noise and long-run indications that arrived as inputs.

Top module: `rx_deframer`

## Requirements
- R1: After reset every output is 0.
- R2: While rx_go_n is high the block is idle and sync_o and frm_o read 0. The first clock with rx_go_n low starts a reception: sydn_o, crc_rdy, crc_err and the latched noise and long-run indications are cleared, and bits are accepted from the next clock on.
- R3: While hunting, sync_o rises on the clock that accepts a bit when the most recent SYNC_W accepted bits equal cfg_sync. The oldest bit is compared with cfg_sync's MSB. At least SYNC_W bits must have been accepted since the start. sync_o stays high until the frame ends or rx_go_n rises.
- R4: After sync, frm_o rises on the clock that accepts a bit when the most recent DELIM_W accepted bits equal cfg_delim, compared MSB first. Any number of extra sync words may come before the delimiter. frm_o implies sync_o.
- R5: A high noise_in or long_in on any clock while hunting is latched, and from that clock on no sync match is taken.
- R6: While hunting, the block counts accepted bits. On the clock that accepts bit number cfg_timeout (cfg_timeout at least 1) without a sync match, sydn_o is set, irq_o pulses for exactly one clock, and reception stops. If sync is found first, the timer never fires.
- R7: ch_busy is sydn_o with neither indication latched. ch_clear is sydn_o with noise or long-run latched.
- R8: cfg_stuff selects the stuffing group: 0 means no stuffing, and codes 1, 2 and 3 mean groups of 4, 8 and 16 data bits. After each full group of data bits following the delimiter, the next received bit is discarded.
- R9: Data bits fill bytes LSB first. Each completed byte drives fifo_wr high for one clock with the byte on fifo_data.
- R10: With len_valid high and length L = {len_hi,len_lo}, the clock that writes byte L+4 also sets crc_rdy and clears sync_o and frm_o. No further bytes are written. L may be loaded at any time before that byte completes.
- R11: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, seed all ones) taken over the payload and the four received CRC bytes. It passes when the residue is 0xC704DD7B in normal bit order, which is 0xDEBB20E3 in the LSB-first register. crc_err is 1 on a miss and 0 on a pass.
- R12: While len_valid is low, no check is made and bytes keep being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_go_n | input | 1 | Receive commence, active low |
| bit_en | input | 1 | Recovered-bit strobe |
| bit_in | input | 1 | Recovered data bit |
| noise_in | input | 1 | Noise indication |
| long_in | input | 1 | Long-run indication |
| cfg_sync | input | SYNC_W | Sync word, first bit in MSB |
| cfg_delim | input | DELIM_W | Frame delimiter, first bit in MSB |
| cfg_stuff | input | 2 | Stuffing group code |
| cfg_timeout | input | TMR_W | Sync limit in bit times |
| len_lo | input | LEN_W/2 | Payload length, low byte |
| len_hi | input | LEN_W/2 | Payload length, high byte |
| len_valid | input | 1 | Length qualifier |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| sync_o | output | 1 | Sync achieved |
| frm_o | output | 1 | Delimiter recognised |
| sydn_o | output | 1 | Sync timer expired |
| irq_o | output | 1 | Interrupt pulse on expiry |
| ch_busy | output | 1 | Channel busy verdict |
| ch_clear | output | 1 | Channel clear verdict |
| crc_rdy | output | 1 | CRC checked |
| crc_err | output | 1 | CRC mismatch |

## Verification
The hardest case to reach from the ports is a length that becomes valid only while payload bytes are already streaming. In that case the end of the frame also coincides with a stuffed bit trailing the last CRC bit. The stimulus holds len_valid low until half the frame's bits have been sent, uses a group length that divides the frame's bit count, and appends extra bytes after the CRC so that any write past the end shows up. Noise and long-run aborts are exercised by placing valid sync words after the indication, so that a missed abort would raise sync_o.

// File: rtl/rx_deframer.sv
`timescale 1ns/1ps
module rx_deframer #(
  parameter int SYNC_W  = 11,
  parameter int DELIM_W = 37,
  parameter int TMR_W   = 16,
  parameter int LEN_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_go_n,
  input  logic                 bit_en,
  input  logic                 bit_in,
  input  logic                 noise_in,
  input  logic                 long_in,
  input  logic [SYNC_W-1:0]    cfg_sync,
  input  logic [DELIM_W-1:0]   cfg_delim,
  input  logic [1:0]           cfg_stuff,
  input  logic [TMR_W-1:0]     cfg_timeout,
  input  logic [LEN_W/2-1:0]   len_lo,
  input  logic [LEN_W/2-1:0]   len_hi,
  input  logic                 len_valid,
  output logic                 fifo_wr,
  output logic [7:0]           fifo_data,
  output logic                 sync_o,
  output logic                 frm_o,
  output logic                 sydn_o,
  output logic                 irq_o,
  output logic                 ch_busy,
  output logic                 ch_clear,
  output logic                 crc_rdy,
  output logic                 crc_err
);
  localparam int HIST_W = (SYNC_W > DELIM_W) ? SYNC_W : DELIM_W;
  localparam int FILL_W = $clog2(HIST_W + 1);
  localparam int CNT_W  = LEN_W + 1;
  localparam logic [31:0] POLY    = 32'hEDB88320;
  localparam logic [31:0] RESIDUE = 32'hDEBB20E3;

  typedef enum logic [2:0] {S_IDLE, S_HUNT, S_SYNC, S_DATA, S_DONE} st_t;
  st_t st;

  logic [HIST_W-1:0] hist;
  logic [FILL_W-1:0] fill;
  logic [TMR_W-1:0]  tmr;
  logic              ns_f, lg_f;
  logic [4:0]        grp;
  logic [2:0]        nbit;
  logic [7:0]        shreg;
  logic [CNT_W-1:0]  bytes;
  logic [31:0]       crc;

  wire [HIST_W-1:0] hist_n   = {hist[HIST_W-2:0], bit_in};
  wire              stopped  = ns_f | lg_f | noise_in | long_in;
  wire              sync_hit = (hist_n[SYNC_W-1:0] == cfg_sync) &&
                               (fill >= FILL_W'(SYNC_W - 1));
  wire              dlm_hit  = (hist_n[DELIM_W-1:0] == cfg_delim) &&
                               (fill >= FILL_W'(DELIM_W - 1));
  wire              tmo_hit  = (tmr == cfg_timeout - TMR_W'(1));
  wire [4:0]        glen     = 5'd2 << cfg_stuff;
  wire              stuff_on = (cfg_stuff != 2'd0);
  wire              drop     = stuff_on && (grp == glen);
  wire [31:0]       crc_n    = {1'b0, crc[31:1]} ^ ((crc[0] ^ bit_in) ? POLY : 32'd0);
  wire [7:0]        byte_n   = {bit_in, shreg[7:1]};
  wire [CNT_W-1:0]  last_cnt = {1'b0, len_hi, len_lo} + CNT_W'(4);
  wire              at_end   = len_valid && ((bytes + CNT_W'(1)) == last_cnt);

  assign ch_busy  = sydn_o & ~(ns_f | lg_f);
  assign ch_clear = sydn_o &  (ns_f | lg_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      hist <= '0; fill <= '0; tmr <= '0;
      ns_f <= 1'b0; lg_f <= 1'b0;
      grp <= '0; nbit <= '0; shreg <= '0; bytes <= '0; crc <= '1;
      fifo_wr <= 1'b0; fifo_data <= '0;
      sync_o <= 1'b0; frm_o <= 1'b0; sydn_o <= 1'b0; irq_o <= 1'b0;
      crc_rdy <= 1'b0; crc_err <= 1'b0;
    end else begin
      irq_o   <= 1'b0;
      fifo_wr <= 1'b0;
      if (rx_go_n) begin
        st <= S_IDLE;
        sync_o <= 1'b0;
        frm_o  <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st <= S_HUNT;
            hist <= '0; fill <= '0; tmr <= '0;
            ns_f <= 1'b0; lg_f <= 1'b0;
            sydn_o <= 1'b0; crc_rdy <= 1'b0; crc_err <= 1'b0;
          end
          S_HUNT: begin
            ns_f <= ns_f | noise_in;
            lg_f <= lg_f | long_in;
            if (bit_en) begin
              hist <= hist_n;
              if (fill != FILL_W'(HIST_W)) fill <= fill + FILL_W'(1);
              if (sync_hit && !stopped) begin
                st <= S_SYNC;
                sync_o <= 1'b1;
              end else if (tmo_hit) begin
                st <= S_DONE;
                sydn_o <= 1'b1;
                irq_o <= 1'b1;
              end else begin
                tmr <= tmr + TMR_W'(1);
              end
            end
          end
          S_SYNC: begin
            if (bit_en) begin
              hist <= hist_n;
              if (fill != FILL_W'(HIST_W)) fill <= fill + FILL_W'(1);
              if (dlm_hit) begin
                st <= S_DATA;
                frm_o <= 1'b1;
                grp <= '0; nbit <= '0; bytes <= '0; crc <= '1;
              end
            end
          end
          S_DATA: begin
            if (bit_en) begin
              if (drop) begin
                grp <= '0;
              end else begin
                if (stuff_on) grp <= grp + 5'd1;
                crc   <= crc_n;
                shreg <= byte_n;
                nbit  <= nbit + 3'd1;
                if (nbit == 3'd7) begin
                  fifo_wr   <= 1'b1;
                  fifo_data <= byte_n;
                  bytes     <= bytes + CNT_W'(1);
                  if (at_end) begin
                    st <= S_DONE;
                    crc_rdy <= 1'b1;
                    crc_err <= (crc_n != RESIDUE);
                    sync_o <= 1'b0;
                    frm_o  <= 1'b0;
                  end
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_frm_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frm_o |-> sync_o);
  a_r3_sync_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> $past(bit_en));
  a_r6_irq_with_sydn: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sydn_o && !sync_o));
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r11_err_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> crc_rdy);
  a_r10_quiet_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_rdy && $past(crc_rdy)) |-> !fifo_wr);
  a_r9_wr_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(bit_en));
endmodule

// File: tb/rx_deframer_tb.sv
`timescale 1ns/1ps
module rx_deframer_tb;
  localparam int SW = 11, DW = 37, TW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, go_n = 1'b1, ben = 1'b0, bin = 1'b0, noise = 1'b0, lng = 1'b0;
  logic [SW-1:0] sync_cfg = 11'h789;
  logic [DW-1:0] delim_cfg = 37'h1A5C3E96D1;
  logic [1:0] stf = 2'd0;
  logic [TW-1:0] tmo = 16'd1000;
  logic [7:0] llo = 8'd0, lhi = 8'd0;
  logic lv = 1'b0;

  logic fifo_wr, sync_o, frm_o, sydn_o, irq_o, ch_busy, ch_clear, crc_rdy, crc_err;
  logic [7:0] fifo_data;

  rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_go_n(go_n), .bit_en(ben), .bit_in(bin),
    .noise_in(noise), .long_in(lng), .cfg_sync(sync_cfg), .cfg_delim(delim_cfg),
    .cfg_stuff(stf), .cfg_timeout(tmo), .len_lo(llo), .len_hi(lhi), .len_valid(lv),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .sync_o(sync_o), .frm_o(frm_o),
    .sydn_o(sydn_o), .irq_o(irq_o), .ch_busy(ch_busy), .ch_clear(ch_clear),
    .crc_rdy(crc_rdy), .crc_err(crc_err));

  int checks = 0, fails = 0;
  int m_st = 0, m_tmr = 0, m_grp = 0, m_nbit = 0, m_bytes = 0;
  bit m_sync, m_frm, m_sydn, m_irq, m_rdy, m_err, m_wr, m_ns, m_lg;
  logic [7:0] m_byte, m_wd;
  logic [31:0] m_crc;
  bit hq[$];
  logic [7:0] got[$];

  function automatic logic [31:0] crc_bit(logic [31:0] c, bit b);
    logic fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c ^= 32'hEDB88320;
    return c;
  endfunction

  function automatic bit tail_eq(int n, logic [63:0] pat);
    if (hq.size() < n) return 1'b0;
    for (int i = 0; i < n; i++)
      if (hq[hq.size()-1-i] != pat[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int len;
    bit stopped;
    m_irq = 0; m_wr = 0;
    if (!rst_n) begin
      m_st = 0; m_sync = 0; m_frm = 0; m_sydn = 0; m_rdy = 0; m_err = 0;
      m_ns = 0; m_lg = 0; m_tmr = 0; hq.delete();
    end else if (go_n) begin
      m_st = 0; m_sync = 0; m_frm = 0;
    end else begin
      case (m_st)
        0: begin
          m_st = 1; m_sydn = 0; m_rdy = 0; m_err = 0; m_ns = 0; m_lg = 0;
          m_tmr = 0; hq.delete();
        end
        1: begin
          stopped = m_ns || m_lg || noise || lng;
          m_ns = m_ns || noise; m_lg = m_lg || lng;
          if (ben) begin
            hq.push_back(bin);
            if (hq.size() > 64) void'(hq.pop_front());
            if (!stopped && tail_eq(SW, 64'(sync_cfg))) begin m_st = 2; m_sync = 1; end
            else begin
              m_tmr++;
              if (m_tmr == int'(tmo)) begin m_sydn = 1; m_irq = 1; m_st = 4; end
            end
          end
        end
        2: if (ben) begin
          hq.push_back(bin);
          if (hq.size() > 64) void'(hq.pop_front());
          if (tail_eq(DW, 64'(delim_cfg))) begin
            m_st = 3; m_frm = 1; m_grp = 0; m_nbit = 0; m_bytes = 0;
            m_byte = 0; m_crc = '1;
          end
        end
        3: if (ben) begin
          if (stf != 0 && m_grp == (2 << stf)) m_grp = 0;
          else begin
            if (stf != 0) m_grp++;
            m_crc = crc_bit(m_crc, bin);
            m_byte[m_nbit] = bin;
            m_nbit++;
            if (m_nbit == 8) begin
              m_wr = 1; m_wd = m_byte; m_byte = 0; m_nbit = 0; m_bytes++;
              len = {lhi, llo};
              if (lv && m_bytes == len + 4) begin
                m_rdy = 1; m_err = (m_crc != 32'hDEBB20E3);
                m_st = 4; m_sync = 0; m_frm = 0;
              end
            end
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("R3", "sync_o", sync_o, m_sync);
    chk("R4", "frm_o", frm_o, m_frm);
    chk("R6", "sydn_o", sydn_o, m_sydn);
    chk("R6", "irq_o", irq_o, m_irq);
    chk("R7", "ch_busy", ch_busy, m_sydn && !m_ns && !m_lg);
    chk("R7", "ch_clear", ch_clear, m_sydn && (m_ns || m_lg));
    chk("R10", "crc_rdy", crc_rdy, m_rdy);
    chk("R11", "crc_err", crc_err, m_err);
    chk("R9", "fifo_wr", fifo_wr, m_wr);
    if (fifo_wr && m_wr) chk("R9", "fifo_data", fifo_data, m_wd);
    if (fifo_wr) got.push_back(fifo_data);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic send_bit(bit b, int gap);
    ben = 1'b1; bin = b; tick();
    ben = 1'b0;
    repeat (gap) tick();
  endtask

  task automatic commence();
    go_n = 1'b1; tick();
    go_n = 1'b0; tick();
  endtask

  // lmode: 0 length valid early, 1 valid halfway, 2 never valid
  task automatic run_frame(int nsync, logic [7:0] pay[$], int code, int lmode,
                           bit corrupt, int gap, int extra);
    logic [31:0] c = '1;
    logic [7:0] all[$];
    int cnt = 0, n = 0, total;
    all = pay;
    foreach (pay[i]) for (int k = 0; k < 8; k++) c = crc_bit(c, pay[i][k]);
    c = ~c;
    if (corrupt) c[5] = ~c[5];
    for (int k = 0; k < 4; k++) all.push_back(c[8*k +: 8]);
    stf = 2'(code); lhi = 8'(pay.size() >> 8); llo = 8'(pay.size());
    lv = (lmode == 0);
    commence();
    for (int i = 0; i < 8; i++) send_bit(i % 2, gap);
    for (int s = 0; s < nsync; s++)
      for (int i = SW-1; i >= 0; i--) send_bit(sync_cfg[i], gap);
    for (int i = DW-1; i >= 0; i--) send_bit(delim_cfg[i], gap);
    got.delete();
    total = all.size() * 8;
    for (int x = 0; x < extra; x++) all.push_back(8'h5A);
    foreach (all[i]) for (int k = 0; k < 8; k++) begin
      n++;
      if (lmode == 1 && n == total / 2) lv = 1'b1;
      send_bit(all[i][k], gap);
      cnt++;
      if (code != 0 && cnt == (2 << code)) begin send_bit(!all[i][k], gap); cnt = 0; end
    end
    repeat (4) tick();
    chk("R10", "bytes written", got.size(), (lmode == 2) ? all.size() : all.size() - extra);
    for (int i = 0; i < got.size() && i < all.size(); i++)
      chk("R8", "received byte", got[i], all[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R1 reset state
    chk("R1", "sync_o", sync_o, 0);
    chk("R1", "fifo_wr", fifo_wr, 0);
    chk("R1", "sydn_o", sydn_o, 0);
    chk("R1", "crc_rdy", crc_rdy, 0);

    run_frame(3, '{8'h12, 8'h34, 8'hAB, 8'h00, 8'hFF}, 0, 0, 0, 1, 2);
    chk("R11", "crc_rdy A", crc_rdy, 1);
    chk("R11", "crc_err A", crc_err, 0);
    chk("R10", "sync_o cleared at end", sync_o, 0);

    run_frame(1, '{8'hFF, 8'hFF, 8'h00}, 1, 1, 0, 0, 2);
    chk("R10", "late length rdy", crc_rdy, 1);
    chk("R11", "crc_err B", crc_err, 0);

    run_frame(2, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 3, 0, 1, 2, 1);
    chk("R11", "corrupt crc_err", crc_err, 1);

    go_n = 1'b1; tick();
    chk("R2", "rdy held while idle", crc_rdy, 1);
    go_n = 1'b0; tick();
    chk("R2", "rdy cleared on start", crc_rdy, 0);
    chk("R2", "err cleared on start", crc_err, 0);

    run_frame(4, '{}, 2, 0, 0, 1, 1);
    chk("R10", "empty payload rdy", crc_rdy, 1);
    chk("R11", "empty payload err", crc_err, 0);

    run_frame(1, '{8'hC3, 8'h3C, 8'h81}, 0, 2, 0, 1, 2);
    chk("R12", "no check without length", crc_rdy, 0);
    lv = 1'b0;

    // R6/R7 busy channel
    tmo = 16'd30; commence();
    for (int i = 0; i < 40; i++) send_bit(i % 2, 0);
    chk("R6", "sydn after limit", sydn_o, 1);
    chk("R7", "busy", ch_busy, 1);
    chk("R7", "not clear", ch_clear, 0);

    // R5 noise abort
    tmo = 16'd70; commence();
    for (int i = 0; i < 4; i++) send_bit(i % 2, 1);
    noise = 1'b1; tick(); noise = 1'b0;
    for (int s = 0; s < 3; s++) for (int i = SW-1; i >= 0; i--) send_bit(sync_cfg[i], 0);
    chk("R5", "no sync after noise", sync_o, 0);
    for (int i = 0; i < 40; i++) send_bit(i % 2, 0);
    chk("R7", "clear after noise", ch_clear, 1);
    chk("R7", "not busy after noise", ch_busy, 0);

    // R5 long-run abort
    commence(); lng = 1'b1;
    for (int s = 0; s < 3; s++) for (int i = SW-1; i >= 0; i--) send_bit(sync_cfg[i], 1);
    chk("R5", "no sync after long", sync_o, 0);
    for (int i = 0; i < 40; i++) send_bit(1, 0);
    lng = 1'b0; tick();
    chk("R7", "clear after long", ch_clear, 1);

    // R6 sync before limit
    tmo = 16'd25; commence();
    for (int i = 0; i < 8; i++) send_bit(i % 2, 0);
    for (int i = SW-1; i >= 0; i--) send_bit(sync_cfg[i], 0);
    for (int i = 0; i < 50; i++) send_bit(i % 2, 0);
    chk("R6", "no expiry after sync", sydn_o, 0);
    chk("R3", "sync held", sync_o, 1);

    // R2 abort mid frame
    tmo = 16'd1000; stf = 2'd0; commence();
    for (int i = SW-1; i >= 0; i--) send_bit(sync_cfg[i], 0);
    for (int i = DW-1; i >= 0; i--) send_bit(delim_cfg[i], 0);
    for (int i = 0; i < 20; i++) send_bit(i % 3 == 0, 0);
    chk("R4", "frame seen", frm_o, 1);
    go_n = 1'b1; tick();
    chk("R2", "sync_o cleared", sync_o, 0);
    chk("R2", "frm_o cleared", frm_o, 0);
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule